// File: doc/BRIEF.md
# Integer ALU with Per-Operation Flag Update

This block is the 32-bit arithmetic and logic stage of a small RISC core. Each cycle it may accept one operation. An operation consists of two register operands, a 16-bit immediate field, a 5-bit operation code and the current four-bit status word. One clock edge later it presents a result word and an updated status word. The register file sits outside the block, and so do writeback, division and any saturation logic.

The zero, sign, carry and overflow flags change differently from one operation to the next. Arithmetic rewrites all four flags. Bitwise operations refresh zero and sign, clear overflow and leave carry untouched. The AND-with-immediate form also forces sign low. Moves, address forms and the halfword multiply pass the incoming status word through unchanged. Immediates are sign-extended for the add and address forms and zero-extended for the bitwise forms.

Top module: `alu_flag_unit`

## Requirements
- R1: Opcodes 0x00 (opb+opa), 0x01 (opb + sign-extended imm_in[4:0]) and 0x02 (opb + sign-extended imm_in[15:0]) produce the 32-bit sum. Carry (status bit 2) is set when the unsigned sum is below either addend. Overflow (bit 3) is set when both addends have the same sign and the sum's sign differs. Zero (bit 0) is set when all 32 result bits are 0. Sign (bit 1) equals result bit 31.
- R2: Opcode 0x03 returns opb-opa. Carry is set when opb is below opa as unsigned values (a borrow). Overflow is set when the operand signs differ and the result's sign differs from opb. Zero and sign follow the R1 rule.
- R3: Opcode 0x04 returns opa-opb. Carry is set when opa is below opb as unsigned values. Overflow is set when the operand signs differ and the result's sign differs from opa. Zero and sign follow the R1 rule.
- R4: Opcodes 0x09 OR, 0x0B AND and 0x0D XOR combine opa with opb. Opcodes 0x0A OR and 0x0E XOR combine opb with zero-extended imm_in. Opcode 0x0F returns the bitwise inverse of opa. Each of these updates zero and sign, clears overflow and keeps the incoming carry.
- R5: Opcode 0x0C returns opb AND zero-extended imm_in. It updates zero, clears sign and overflow, and keeps carry.
- R6: Opcode 0x10 returns the unsigned product of opa[15:0] and opb[15:0]. Opcode 0x11 returns the unsigned product of opb[15:0] and imm_in. Both return the full 32-bit product, and the status word passes through unchanged.
- R7: The move and address forms pass the status word through unchanged. Opcode 0x05 returns opa. Opcode 0x06 returns sign-extended imm_in[4:0]. Opcode 0x07 returns opb + sign-extended imm_in. Opcode 0x08 returns opb + (imm_in shifted left by 16).
- R8: out_valid equals in_valid of the previous cycle. result and status_out are loaded only in a cycle with in_valid high and otherwise hold their values.
- R9: While rst_n is low, result and status_out read 0 and out_valid reads 0.
- R10: Opcodes 0x12 to 0x1F return a result of 0 and pass the status word through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | Operation present this cycle |
| op_in | input | 5 | Operation code |
| opa | input | 32 | First register operand (subtrahend of 0x03) |
| opb | input | 32 | Second register operand (minuend of 0x03) |
| imm_in | input | 16 | Immediate field; bits 4:0 form the short immediate |
| status_in | input | 4 | Current status word: bit 0 zero, 1 sign, 2 carry, 3 overflow |
| out_valid | output | 1 | Result and status registered from the previous cycle |
| result | output | 32 | Operation result |
| status_out | output | 4 | Updated status word, same bit layout as status_in |

## Verification
Every operation's result and status word are due exactly one rising edge after the cycle in which in_valid was high, and out_valid follows in_valid with the same one-edge delay. The bench drives each operation on a falling edge. It updates its behavioural model at the next rising edge and compares result, status_out and out_valid on the falling edge after that, so every comparison lands in the cycle the registered outputs change. Idle cycles go through the same comparison against the held model values, which covers the hold behaviour. Corner operands cover signed and unsigned wrap, borrow in both subtract directions and the largest halfword product.

// File: rtl/alu_flag_pkg.sv
`timescale 1ns/1ps
package alu_flag_pkg;

  localparam int FLAG_Z = 0;
  localparam int FLAG_S = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_N = 4;

  typedef enum logic [4:0] {
    OP_ADD     = 5'h00,
    OP_ADD_S5  = 5'h01,
    OP_ADD_S16 = 5'h02,
    OP_SUB     = 5'h03,
    OP_RSUB    = 5'h04,
    OP_MOV     = 5'h05,
    OP_MOV_S5  = 5'h06,
    OP_ADR_LO  = 5'h07,
    OP_ADR_HI  = 5'h08,
    OP_OR      = 5'h09,
    OP_OR_I    = 5'h0A,
    OP_AND     = 5'h0B,
    OP_AND_I   = 5'h0C,
    OP_XOR     = 5'h0D,
    OP_XOR_I   = 5'h0E,
    OP_NOT     = 5'h0F,
    OP_MUL     = 5'h10,
    OP_MUL_I   = 5'h11
  } alu_op_e;

  typedef enum logic [1:0] {
    AS_ADD  = 2'd0,
    AS_BMA  = 2'd1,
    AS_AMB  = 2'd2
  } addsub_e;

  typedef enum logic [1:0] {
    BW_OR  = 2'd0,
    BW_AND = 2'd1,
    BW_XOR = 2'd2,
    BW_INV = 2'd3
  } bitwise_e;

endpackage

// File: rtl/alu_imm_ext.sv
`timescale 1ns/1ps
module alu_imm_ext #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHORT_W = 5
) (
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] sext_short,
  output logic [DATA_W-1:0] sext_long,
  output logic [DATA_W-1:0] zext_long,
  output logic [DATA_W-1:0] high_long
);
  localparam int SHORT_PAD = DATA_W - SHORT_W;
  localparam int LONG_PAD  = DATA_W - IMM_W;

  always_comb begin
    sext_short = {{SHORT_PAD{imm[SHORT_W-1]}}, imm[SHORT_W-1:0]};
    sext_long  = {{LONG_PAD{imm[IMM_W-1]}}, imm};
    zext_long  = {{LONG_PAD{1'b0}}, imm};
    high_long  = {imm, {LONG_PAD{1'b0}}};
  end
endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub import alu_flag_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  addsub_e           kind,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    wide  = '0;
    ovf   = 1'b0;
    unique case (kind)
      AS_BMA: begin
        wide = {1'b0, y} - {1'b0, x};
        ovf  = (y[MSB] != x[MSB]) && (wide[MSB] != y[MSB]);
      end
      AS_AMB: begin
        wide = {1'b0, x} - {1'b0, y};
        ovf  = (x[MSB] != y[MSB]) && (wide[MSB] != x[MSB]);
      end
      default: begin
        wide = {1'b0, y} + {1'b0, x};
        ovf  = (y[MSB] == x[MSB]) && (wide[MSB] != y[MSB]);
      end
    endcase
    sum   = wide[DATA_W-1:0];
    carry = wide[DATA_W];
  end
endmodule

// File: rtl/alu_bitwise.sv
`timescale 1ns/1ps
module alu_bitwise import alu_flag_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  bitwise_e          kind,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] r
);
  always_comb begin
    unique case (kind)
      BW_AND:  r = x & y;
      BW_XOR:  r = x ^ y;
      BW_INV:  r = ~x;
      default: r = x | y;
    endcase
  end
endmodule

// File: rtl/alu_halfmul.sv
`timescale 1ns/1ps
module alu_halfmul #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  output logic [DATA_W-1:0] p
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] xl;
  logic [HALF_W-1:0] yl;

  always_comb begin
    xl = x[HALF_W-1:0];
    yl = y[HALF_W-1:0];
    p  = DATA_W'(xl) * DATA_W'(yl);
  end
endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit import alu_flag_pkg::*; #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int SHORT_W = 5,
  parameter int OP_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_in,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [IMM_W-1:0]  imm_in,
  input  logic [FLAG_N-1:0] status_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_N-1:0] status_out
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] imm_s5, imm_s16, imm_z16, imm_hi;
  addsub_e           as_kind;
  bitwise_e          bw_kind;
  logic [DATA_W-1:0] as_x, bw_x, bw_y, mul_y;
  logic [DATA_W-1:0] as_sum, bw_res, mul_res;
  logic              as_carry, as_ovf;
  logic [DATA_W-1:0] res_d;
  logic [FLAG_N-1:0] st_d;
  logic              valid_q;
  logic [DATA_W-1:0] res_q;
  logic [FLAG_N-1:0] st_q;

  alu_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SHORT_W(SHORT_W)) u_ext (
    .imm        (imm_in),
    .sext_short (imm_s5),
    .sext_long  (imm_s16),
    .zext_long  (imm_z16),
    .high_long  (imm_hi)
  );

  // Operand steering for the shared adder, the bitwise unit and the multiplier
  always_comb begin
    as_kind = AS_ADD;
    as_x    = opa;
    bw_kind = BW_OR;
    bw_x    = opa;
    bw_y    = opb;
    mul_y   = opa;
    unique case (op_in)
      OP_ADD_S5:  as_x = imm_s5;
      OP_ADD_S16: as_x = imm_s16;
      OP_ADR_LO:  as_x = imm_s16;
      OP_ADR_HI:  as_x = imm_hi;
      OP_SUB:     as_kind = AS_BMA;
      OP_RSUB:    as_kind = AS_AMB;
      OP_OR_I:    bw_x = imm_z16;
      OP_AND:     bw_kind = BW_AND;
      OP_AND_I: begin
        bw_kind = BW_AND;
        bw_x    = imm_z16;
      end
      OP_XOR:     bw_kind = BW_XOR;
      OP_XOR_I: begin
        bw_kind = BW_XOR;
        bw_x    = imm_z16;
      end
      OP_NOT:     bw_kind = BW_INV;
      OP_MUL_I:   mul_y = imm_z16;
      default: ;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .kind  (as_kind),
    .x     (as_x),
    .y     (opb),
    .sum   (as_sum),
    .carry (as_carry),
    .ovf   (as_ovf)
  );

  alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .kind (bw_kind),
    .x    (bw_x),
    .y    (bw_y),
    .r    (bw_res)
  );

  alu_halfmul #(.DATA_W(DATA_W)) u_mul (
    .x (opb),
    .y (mul_y),
    .p (mul_res)
  );

  // Result selection and per-operation flag policy
  always_comb begin
    res_d = '0;
    st_d  = status_in;
    unique case (op_in)
      OP_ADD, OP_ADD_S5, OP_ADD_S16, OP_SUB, OP_RSUB: begin
        res_d          = as_sum;
        st_d[FLAG_Z]   = (as_sum == '0);
        st_d[FLAG_S]   = as_sum[MSB];
        st_d[FLAG_C]   = as_carry;
        st_d[FLAG_V]   = as_ovf;
      end
      OP_MOV:              res_d = opa;
      OP_MOV_S5:           res_d = imm_s5;
      OP_ADR_LO, OP_ADR_HI: res_d = as_sum;
      OP_OR, OP_OR_I, OP_AND, OP_XOR, OP_XOR_I, OP_NOT: begin
        res_d          = bw_res;
        st_d[FLAG_Z]   = (bw_res == '0);
        st_d[FLAG_S]   = bw_res[MSB];
        st_d[FLAG_V]   = 1'b0;
      end
      OP_AND_I: begin
        res_d          = bw_res;
        st_d[FLAG_Z]   = (bw_res == '0);
        st_d[FLAG_S]   = 1'b0;
        st_d[FLAG_V]   = 1'b0;
      end
      OP_MUL, OP_MUL_I:    res_d = mul_res;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      st_q  <= '0;
    end else if (in_valid) begin
      res_q <= res_d;
      st_q  <= st_d;
    end
  end

  assign out_valid  = valid_q;
  assign result     = res_q;
  assign status_out = st_q;
endmodule

// File: rtl/alu_flag_unit_chk.sv
`timescale 1ns/1ps
module alu_flag_unit_chk import alu_flag_pkg::*; (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [4:0]  op_in,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic [15:0] imm_in,
  input logic [3:0]  status_in,
  input logic        out_valid,
  input logic [31:0] result,
  input logic [3:0]  status_out
);
  logic add_grp, logic_grp, keep_grp;

  always_comb begin
    add_grp   = (op_in == OP_ADD) || (op_in == OP_ADD_S5) || (op_in == OP_ADD_S16);
    logic_grp = (op_in == OP_OR) || (op_in == OP_OR_I) || (op_in == OP_AND) ||
                (op_in == OP_XOR) || (op_in == OP_XOR_I) || (op_in == OP_NOT);
    keep_grp  = (op_in == OP_MOV) || (op_in == OP_MOV_S5) ||
                (op_in == OP_ADR_LO) || (op_in == OP_ADR_HI);
  end

  p_zero_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && add_grp) |-> (status_out[0] == (result == 32'd0)));

  p_sub_borrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_in == OP_SUB) |-> (status_out[2] == ($past(opb) < $past(opa))));

  p_rsub_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_in == OP_RSUB) |-> (result == $past(opa) - $past(opb)));

  p_logic_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && logic_grp) |-> (status_out[2] == $past(status_in[2]) && !status_out[3]));

  p_andi_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_in == OP_AND_I) |-> (!status_out[1] && !status_out[3]));

  p_mul_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && (op_in == OP_MUL || op_in == OP_MUL_I)) |-> (status_out == $past(status_in)));

  p_move_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && keep_grp) |-> (status_out == $past(status_in)));

  p_valid_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(result) && $stable(status_out)));

  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && op_in >= 5'h12) |-> (result == 32'd0 && status_out == $past(status_in)));

  always_comb begin
    if (!rst_n) begin
      a_reset_r9: assert (out_valid == 1'b0 && result == 32'd0 && status_out == 4'd0);
    end
  end
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (.*);

// File: tb/alu_flag_unit_tb.sv
`timescale 1ns/1ps
module alu_flag_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op_in;
  logic [31:0] opa, opb;
  logic [15:0] imm_in;
  logic [3:0]  status_in;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  status_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] exp_res;
  logic [3:0]  exp_st;
  logic        exp_v;

  alu_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_in(op_in),
    .opa(opa), .opb(opb), .imm_in(imm_in), .status_in(status_in),
    .out_valid(out_valid), .result(result), .status_out(status_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'h00, 5'h01, 5'h02: return "R1";
      5'h03: return "R2";
      5'h04: return "R3";
      5'h09, 5'h0A, 5'h0B, 5'h0D, 5'h0E, 5'h0F: return "R4";
      5'h0C: return "R5";
      5'h10, 5'h11: return "R6";
      5'h05, 5'h06, 5'h07, 5'h08: return "R7";
      default: return "R10";
    endcase
  endfunction

  // Behavioural reference: returns {status, result}
  function automatic logic [35:0] model(input logic [4:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] im,
                                        input logic [3:0] st);
    logic [31:0] s5, s16, z16, r, x;
    logic [3:0]  f;
    longint      sa, sb, sr;
    bit          upd_all, upd_log;
    s5  = {{27{im[4]}}, im[4:0]};
    s16 = {{16{im[15]}}, im};
    z16 = {16'd0, im};
    f = st; r = 32'd0; upd_all = 0; upd_log = 0;
    case (o)
      5'h00, 5'h01, 5'h02: begin
        x  = (o == 5'h00) ? a : ((o == 5'h01) ? s5 : s16);
        r  = b + x;
        sa = longint'($signed(b)); sb = longint'($signed(x)); sr = sa + sb;
        f[2] = (r < b) || (r < x);
        f[3] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        upd_all = 1;
      end
      5'h03: begin
        r  = b - a;
        sr = longint'($signed(b)) - longint'($signed(a));
        f[2] = (b < a);
        f[3] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        upd_all = 1;
      end
      5'h04: begin
        r  = a - b;
        sr = longint'($signed(a)) - longint'($signed(b));
        f[2] = (a < b);
        f[3] = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        upd_all = 1;
      end
      5'h05: r = a;
      5'h06: r = s5;
      5'h07: r = b + s16;
      5'h08: r = b + {im, 16'd0};
      5'h09: begin r = a | b;   upd_log = 1; end
      5'h0A: begin r = b | z16; upd_log = 1; end
      5'h0B: begin r = a & b;   upd_log = 1; end
      5'h0D: begin r = a ^ b;   upd_log = 1; end
      5'h0E: begin r = b ^ z16; upd_log = 1; end
      5'h0F: begin r = ~a;      upd_log = 1; end
      5'h0C: begin
        r = b & z16;
        f[0] = (r == 0); f[1] = 1'b0; f[3] = 1'b0;
      end
      5'h10: r = 32'(longint'(a[15:0]) * longint'(b[15:0]));
      5'h11: r = 32'(longint'(im) * longint'(b[15:0]));
      default: r = 32'd0;
    endcase
    if (upd_all || upd_log) begin
      f[0] = (r == 0);
      f[1] = r[31];
    end
    if (upd_log) f[3] = 1'b0;
    return {f, r};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (result !== exp_res || status_out !== exp_st || out_valid !== exp_v) begin
      errors++;
      $display("FAIL %s res=%h st=%h v=%b expected res=%h st=%h v=%b",
               tag, result, status_out, out_valid, exp_res, exp_st, exp_v);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the check
  task automatic step(input logic v, input logic [4:0] o, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] im, input logic [3:0] st);
    logic [35:0] m;
    in_valid = v; op_in = o; opa = a; opb = b; imm_in = im; status_in = st;
    @(posedge clk);
    if (v) begin
      m = model(o, a, b, im, st);
      exp_st  = m[35:32];
      exp_res = m[31:0];
    end
    exp_v = v;
    @(negedge clk);
    compare(v ? tag_of(o) : "R8");
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_in = '0; opa = '0; opb = '0;
    imm_in = '0; status_in = '0;
    exp_res = '0; exp_st = '0; exp_v = 1'b0;
    repeat (3) @(negedge clk);
    compare("R9");                       // R9 reset state while held
    rst_n = 1'b1;
    @(negedge clk);
    compare("R9");                       // R9 state survives release with no input

    // R1 add family corners
    step(1, 5'h00, 32'h0000_0001, 32'h7FFF_FFFF, 16'h0, 4'h0);   // signed overflow
    step(1, 5'h00, 32'h0000_0001, 32'hFFFF_FFFF, 16'h0, 4'h0);   // carry, zero
    step(1, 5'h01, 32'h0,         32'h0000_0010, 16'h001F, 4'hF); // imm5 = -1
    step(1, 5'h02, 32'h0,         32'h8000_0000, 16'h8000, 4'h0); // negative wrap
    // R2 subtract
    step(1, 5'h03, 32'h0000_0001, 32'h0000_0000, 16'h0, 4'h0);   // borrow
    step(1, 5'h03, 32'h0000_0001, 32'h8000_0000, 16'h0, 4'h0);   // overflow
    step(1, 5'h03, 32'h1234_5678, 32'h1234_5678, 16'h0, 4'hF);   // zero
    // R3 reverse subtract
    step(1, 5'h04, 32'h0000_0000, 32'h0000_0001, 16'h0, 4'h0);
    step(1, 5'h04, 32'h8000_0000, 32'h0000_0001, 16'h0, 4'h0);
    // R4 logic keeps carry, clears overflow
    step(1, 5'h09, 32'h8000_0000, 32'h0000_0001, 16'h0, 4'hC);
    step(1, 5'h0B, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 16'h0, 4'h8);
    step(1, 5'h0E, 32'h0,         32'hFFFF_FFFF, 16'hFFFF, 4'h4);
    step(1, 5'h0F, 32'h0000_0000, 32'h0,         16'h0, 4'h8);
    // R5 AND immediate clears sign
    step(1, 5'h0C, 32'h0, 32'hFFFF_8001, 16'h8000, 4'hE);
    step(1, 5'h0C, 32'h0, 32'hFFFF_0000, 16'hFFFF, 4'h6);
    // R6 halfword multiply
    step(1, 5'h10, 32'hABCD_FFFF, 32'h1234_FFFF, 16'h0, 4'h5);
    step(1, 5'h11, 32'h0,         32'h0000_0003, 16'hFFFF, 4'hA);
    // R7 move and address forms
    step(1, 5'h05, 32'hDEAD_BEEF, 32'h0, 16'h0, 4'h9);
    step(1, 5'h06, 32'h0, 32'h0, 16'h0010, 4'h3);
    step(1, 5'h07, 32'h0, 32'h0000_0100, 16'hFFFF, 4'h7);
    step(1, 5'h08, 32'h0, 32'h0000_1234, 16'hABCD, 4'h1);
    // R8 hold over idle cycles with changing inputs
    step(0, 5'h00, 32'h1111_1111, 32'h2222_2222, 16'h1, 4'hF);
    step(0, 5'h0F, 32'h3333_3333, 32'h0, 16'h2, 4'h0);
    // R10 unassigned opcodes
    step(1, 5'h12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 4'hB);
    step(1, 5'h1F, 32'h1, 32'h1, 16'h1, 4'h4);

    // Mixed pattern with random operands, codes and idle gaps
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, 5'($urandom % 20), $urandom, $urandom,
           16'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule